// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block keeps the hotplug bookkeeping for up to 32 device slots. It takes insert and removal notices from the slot side and reports them to host software through a small register window. Host software sees three per-slot masks: which slots need a device check, which slots have a removal pending, and which slots can be hot-removed. It also sees a four-byte general-purpose event (GPE) block that drives the system control interrupt level.

A hot insert or a removal request sets the hotplug status bit in the GPE block. If that bit is enabled, the event output goes high. Software reads the masks, handles the slots, and completes a removal by writing a slot mask to the eject register. Each such write retires one slot: the lowest set bit of the written value. If that slot is hot-removable, the write also sends a one-cycle eject strobe to the slot logic.

A reset completes every removal still pending. It also latches which slots can be hot-removed from the `fixed_mask` input.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: The register window is addressed by `reg_addr`:
  - Words: word 0 (0x00) up mask, word 1 (0x04) down mask, word 2 (0x08) eject on write and feature on read, word 3 (0x0C) removable mask.
  - GPE bytes, returned in bits 7:0 of read data: 0x10 status byte 0, 0x11 status byte 1, 0x12 enable byte 0, 0x13 enable byte 1.
  - Timing: `reg_rdata` carries the value of the addressed register one clock after `reg_rd`.
  - Unused addresses: any other address reads as zero.
- R2: The up mask reads as (present mask AND hotplug-enable mask), so a slot that is present but not hot-removable never appears in it.
- R3: A hot insert (`evt_remove`=0, `evt_cold`=0) sets the slot's present bit and sets bit 1 of GPE status byte 0.
- R4: A cold insert (`evt_remove`=0, `evt_cold`=1) sets the slot's present bit and leaves the GPE status unchanged.
- R5: A removal event (`evt_remove`=1) sets the slot's bit in the down mask and sets bit 1 of GPE status byte 0.
- R6: A write to the eject register handles only the lowest set bit of the written value:
  - That bit is cleared in the down mask.
  - If the slot is hot-removable, its present bit is cleared and `eject_o` shows that single bit for the one cycle after the write.
  - If the slot is not hot-removable, the slot stays present and `eject_o` stays zero.
- R7: An eject write of zero changes neither mask and produces no eject strobe.
- R8: The feature register (read at 0x08) always reads zero. The removable register reads the hotplug-enable mask.
- R9: While `rst` is high:
  - Every pending down bit is completed as an eject: the down mask becomes zero, and each pending slot that is hot-removable loses its present bit.
  - The hotplug-enable mask is loaded with the inverse of `fixed_mask`. After reset, changes on `fixed_mask` have no effect.
  - The GPE bytes, `sci_o`, `eject_o` and `reg_rdata` are cleared.
- R10: GPE status bytes are write-one-to-clear. GPE enable bytes take the written value.
- R11: `sci_o` equals (status byte 0 bit 1 AND enable byte 0 bit 1). It is updated on the same clock edge as the register change that causes it.
- R12: When an event and a clearing write hit the same bit in the same cycle, the event wins:
  - A hot event together with a status write-one-to-clear leaves status bit 1 set.
  - A removal together with an eject of the same slot leaves the down bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; drains pending removals |
| evt_valid | input | 1 | A slot event is presented this cycle |
| evt_slot | input | $clog2(NUM_SLOTS) | Slot number of the event |
| evt_remove | input | 1 | 1: removal request, 0: insert |
| evt_cold | input | 1 | Insert of a device present at boot (no GPE event) |
| fixed_mask | input | NUM_SLOTS | Slots that are not hot-removable, sampled during reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| sci_o | output | 1 | Event level towards the system control interrupt |
| eject_o | output | NUM_SLOTS | One-cycle eject strobe per slot |

## Verification
The bench builds the block with its default parameters: 32 slots, 5 address bits and 32 data bits. With these values the slot masks fill the whole data word, so slot 31 reaches the top bit of every register and of the lowest-set-bit search. The four-byte GPE block then sits directly after the four slot words, so a stray write to a neighbouring byte would show up as a wrong enable or status value. Directed cases cover:
- eject values with several bits set,
- ejects of fixed slots,
- a zero eject,
- coincident set and clear in the same cycle,
- a reset drain across slots 0, 5 and 31.

A seeded random mix of events, ejects and GPE writes then runs against a bench model.

// File: rtl/hp_pkg.sv
package hp_pkg;
  // word index inside the register window (byte address / 4)
  localparam int unsigned WORD_UP    = 0;
  localparam int unsigned WORD_DOWN  = 1;
  localparam int unsigned WORD_EJECT = 2;
  localparam int unsigned WORD_RMV   = 3;
  localparam int unsigned WORD_GPE   = 4;
  // status/enable bit in GPE byte 0 that carries slot events
  localparam int unsigned GPE_HOT_BIT = 1;
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] first
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign first[i]  = vec[i] & ~seen[i];
    assign seen[i+1] = seen[i] | vec[i];
  end
endmodule

// File: rtl/hp_slot_state.sv
module hp_slot_state #(
  parameter int unsigned N  = 32,
  parameter int unsigned SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_valid,
  input  logic [SW-1:0] evt_slot,
  input  logic          evt_remove,
  input  logic          evt_cold,
  input  logic [N-1:0]  fixed_mask,
  input  logic          ej_wr,
  input  logic [N-1:0]  ej_data,
  output logic [N-1:0]  present_o,
  output logic [N-1:0]  down_o,
  output logic [N-1:0]  hpen_o,
  output logic [N-1:0]  eject_o,
  output logic          hot_evt_o
);
  logic [N-1:0] present_q = '0;
  logic [N-1:0] down_q    = '0;
  logic [N-1:0] hpen_q    = '0;
  logic [N-1:0] eject_q   = '0;
  logic         rst_d     = 1'b0;

  logic [N-1:0] first_bit, sel, slot_hot, ins_set, rem_set;

  hp_lowbit #(.W(N)) u_lowbit (.vec(ej_data), .first(first_bit));

  assign sel      = ej_wr ? first_bit : '0;
  assign slot_hot = evt_valid ? (N'(1) << evt_slot) : '0;
  assign ins_set  = evt_remove ? '0 : slot_hot;
  assign rem_set  = evt_remove ? slot_hot : '0;
  assign hot_evt_o = evt_valid & (evt_remove | ~evt_cold);

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      present_q <= present_q & ~(down_q & ~fixed_mask);
      down_q    <= '0;
      hpen_q    <= ~fixed_mask;
      eject_q   <= '0;
    end else begin
      present_q <= (present_q & ~(sel & hpen_q)) | ins_set;
      down_q    <= (down_q & ~sel) | rem_set;
      eject_q   <= sel & hpen_q;
    end
  end

  assign present_o = present_q;
  assign down_o    = down_q;
  assign hpen_o    = hpen_q;
  assign eject_o   = eject_q;

  // R6
  ej_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(eject_q));
  // R6
  ej_source_chk: assert property (@(posedge clk) disable iff (rst)
    (|eject_q) |-> $past(ej_wr));
  // R7
  ej_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ej_wr && ej_data == '0 && !evt_valid) |=> (down_q == $past(down_q) && present_q == $past(present_q)));
  // R9
  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      rst_drain_chk: assert (down_q == '0);
    end
  end
endmodule

// File: rtl/hp_gpe.sv
module hp_gpe #(
  parameter int unsigned HALF = 2,
  parameter int unsigned IW   = $clog2(2 * HALF)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [IW-1:0]        byte_sel,
  input  logic [7:0]           wdata,
  input  logic                 hot_set,
  output logic [HALF-1:0][7:0] sts_o,
  output logic [HALF-1:0][7:0] en_o,
  output logic                 sci_o
);
  import hp_pkg::*;
  localparam logic [7:0] HOT_MASK = 8'(1) << GPE_HOT_BIT;

  logic [HALF-1:0][7:0] sts_q, en_q, sts_d, en_d;
  logic                 sci_q;

  for (genvar b = 0; b < HALF; b++) begin : g_byte
    logic       clr_hit, en_hit;
    logic [7:0] set_bits;
    assign clr_hit  = wr && (byte_sel == IW'(b));
    assign en_hit   = wr && (byte_sel == IW'(HALF + b));
    assign set_bits = (b == 0 && hot_set) ? HOT_MASK : 8'h00;
    assign sts_d[b] = (sts_q[b] & ~(clr_hit ? wdata : 8'h00)) | set_bits;
    assign en_d[b]  = en_hit ? wdata : en_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
      sci_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
      sci_q <= sts_d[0][GPE_HOT_BIT] & en_d[0][GPE_HOT_BIT];
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign sci_o = sci_q;

  // R10
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && byte_sel == '0 && wdata[GPE_HOT_BIT] && !hot_set) |=> !sts_q[0][GPE_HOT_BIT]);
  // R11
  sci_level_chk: assert property (@(posedge clk) disable iff (rst)
    sci_q == (sts_q[0][GPE_HOT_BIT] & en_q[0][GPE_HOT_BIT]));
  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hot_set |=> sts_q[0][GPE_HOT_BIT]);
endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned GPE_HALF  = 2,
  localparam int unsigned SW       = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_valid,
  input  logic [SW-1:0]        evt_slot,
  input  logic                 evt_remove,
  input  logic                 evt_cold,
  input  logic [NUM_SLOTS-1:0] fixed_mask,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 sci_o,
  output logic [NUM_SLOTS-1:0] eject_o
);
  import hp_pkg::*;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned GIW    = $clog2(2 * GPE_HALF);

  logic [WORD_W-1:0]        word;
  logic [GIW-1:0]           gidx;
  logic                     ej_wr, gpe_wr, hot_evt;
  logic [NUM_SLOTS-1:0]     present, down, hpen;
  logic [GPE_HALF-1:0][7:0] gpe_sts, gpe_en;
  logic [2*GPE_HALF-1:0][7:0] gpe_bytes;
  logic [DATA_W-1:0]        rd_next;
  logic [DATA_W-1:0]        rdata_q;

  assign word   = reg_addr[ADDR_W-1:2];
  assign gidx   = reg_addr[GIW-1:0];
  assign ej_wr  = reg_wr && (word == WORD_W'(WORD_EJECT));
  assign gpe_wr = reg_wr && (word == WORD_W'(WORD_GPE));

  hp_slot_state #(.N(NUM_SLOTS)) u_slots (
    .clk(clk), .rst(rst),
    .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_remove(evt_remove), .evt_cold(evt_cold),
    .fixed_mask(fixed_mask),
    .ej_wr(ej_wr), .ej_data(reg_wdata[NUM_SLOTS-1:0]),
    .present_o(present), .down_o(down), .hpen_o(hpen),
    .eject_o(eject_o), .hot_evt_o(hot_evt)
  );

  hp_gpe #(.HALF(GPE_HALF)) u_gpe (
    .clk(clk), .rst(rst),
    .wr(gpe_wr), .byte_sel(gidx), .wdata(reg_wdata[7:0]),
    .hot_set(hot_evt),
    .sts_o(gpe_sts), .en_o(gpe_en), .sci_o(sci_o)
  );

  assign gpe_bytes = {gpe_en, gpe_sts};

  always_comb begin
    rd_next = '0;
    case (word)
      WORD_W'(WORD_UP):   rd_next = DATA_W'(present & hpen);
      WORD_W'(WORD_DOWN): rd_next = DATA_W'(down);
      WORD_W'(WORD_RMV):  rd_next = DATA_W'(hpen);
      WORD_W'(WORD_GPE):  rd_next = DATA_W'(gpe_bytes[gidx]);
      default:            rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_next;
  end

  assign reg_rdata = rdata_q;

  // R4
  cold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_remove && evt_cold && !gpe_sts[0][GPE_HOT_BIT]) |=> !gpe_sts[0][GPE_HOT_BIT]);
  // R5
  remove_down_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_remove) |=> down[$past(evt_slot)]);
endmodule

// File: tb/slot_hotplug_ctrl_bench.sv
module slot_hotplug_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0, evt_remove = 1'b0, evt_cold = 1'b0;
  logic [4:0]  evt_slot = '0;
  logic [31:0] fixed_mask = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sci_o;
  logic [31:0] eject_o;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model
  logic [31:0] m_present = '0, m_down = '0, m_hpen = '0;
  logic [7:0]  m_sts0 = '0, m_sts1 = '0, m_en0 = '0, m_en1 = '0;

  slot_hotplug_ctrl u_slot_hotplug_ctrl (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_remove(evt_remove), .evt_cold(evt_cold), .fixed_mask(fixed_mask),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sci_o(sci_o), .eject_o(eject_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] low_bit(logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  function automatic logic m_sci();
    return m_sts0[1] & m_en0[1];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [4:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    do_read(5'h00, d); chk({tag, " R2 up"}, d, m_present & m_hpen);
    do_read(5'h04, d); chk({tag, " R5 down"}, d, m_down);
    do_read(5'h08, d); chk({tag, " R8 feature"}, d, 32'h0);
    do_read(5'h0C, d); chk({tag, " R8 removable"}, d, m_hpen);
    do_read(5'h10, d); chk({tag, " R10 sts0"}, d, {24'h0, m_sts0});
    do_read(5'h11, d); chk({tag, " R10 sts1"}, d, {24'h0, m_sts1});
    do_read(5'h12, d); chk({tag, " R10 en0"}, d, {24'h0, m_en0});
    do_read(5'h13, d); chk({tag, " R10 en1"}, d, {24'h0, m_en1});
    do_read(5'h18, d); chk({tag, " R1 unused"}, d, 32'h0);
  endtask

  task automatic model_event(int slot, bit rem, bit cold);
    if (rem) begin
      m_down |= (32'd1 << slot);
      m_sts0 |= 8'h02;
    end else begin
      m_present |= (32'd1 << slot);
      if (!cold) m_sts0 |= 8'h02;
    end
  endtask

  task automatic do_event(int slot, bit rem, bit cold);
    evt_valid = 1'b1; evt_slot = 5'(slot); evt_remove = rem; evt_cold = cold;
    @(negedge clk);
    evt_valid = 1'b0;
    model_event(slot, rem, cold);
    chk("R11 sci after event", {31'h0, sci_o}, {31'h0, m_sci()});
  endtask

  task automatic model_write(logic [4:0] a, logic [31:0] d, output logic [31:0] ej);
    logic [31:0] sel;
    ej = '0;
    if (a[4:2] == 3'd2) begin
      sel = low_bit(d);
      ej = sel & m_hpen;
      m_down &= ~sel;
      m_present &= ~ej;
    end else if (a[4:2] == 3'd4) begin
      case (a[1:0])
        2'd0: m_sts0 &= ~d[7:0];
        2'd1: m_sts1 &= ~d[7:0];
        2'd2: m_en0 = d[7:0];
        default: m_en1 = d[7:0];
      endcase
    end
  endtask

  task automatic do_write(logic [4:0] a, logic [31:0] d);
    logic [31:0] ej;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    model_write(a, d, ej);
    chk("R6 eject strobe", eject_o, ej);
    chk("R11 sci after write", {31'h0, sci_o}, {31'h0, m_sci()});
  endtask

  task automatic do_reset(logic [31:0] fx);
    fixed_mask = fx; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_present &= ~(m_down & ~fx);
    m_down = '0; m_hpen = ~fx;
    m_sts0 = '0; m_sts1 = '0; m_en0 = '0; m_en1 = '0;
  endtask

  initial begin
    logic [31:0] d, ej;
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset(32'h0000_0081);
    chk("R9 reset rdata", reg_rdata, 32'h0);
    chk("R9 reset sci", {31'h0, sci_o}, 32'h0);
    chk("R9 reset eject", eject_o, 32'h0);
    check_all("reset");

    // cold inserts: no event
    do_event(5, 0, 1); do_event(7, 0, 1); do_event(0, 0, 1);
    chk("R4 cold no status", {24'h0, m_sts0}, 32'h0);
    check_all("R4 cold");

    // hot insert and enable
    do_event(3, 0, 0);
    check_all("R3 hot insert");
    do_write(5'h12, 32'h02);
    chk("R11 sci high", {31'h0, sci_o}, 32'h1);
    do_write(5'h10, 32'h02);
    chk("R10 w1c clears", {31'h0, sci_o}, 32'h0);

    // event and w1c in one cycle: event wins
    reg_addr = 5'h10; reg_wdata = 32'hFF; reg_wr = 1'b1;
    evt_valid = 1'b1; evt_slot = 5'd9; evt_remove = 1'b0; evt_cold = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0;
    model_write(5'h10, 32'hFF, ej); model_event(9, 0, 0);
    chk("R12 status set wins", {31'h0, sci_o}, 32'h1);
    check_all("R12 set wins");

    // removals and ejects
    do_event(3, 1, 0); do_event(5, 1, 0); do_event(7, 1, 0);
    check_all("R5 removals");
    do_write(5'h08, 32'h0000_0028);
    chk("R6 lowest only", eject_o, 32'h0000_0008);
    check_all("R6 eject lowest");
    do_write(5'h08, 32'h0);
    chk("R7 zero eject", eject_o, 32'h0);
    check_all("R7 zero eject");
    do_write(5'h08, 32'h0000_0080);
    chk("R6 fixed slot no strobe", eject_o, 32'h0);
    check_all("R6 fixed slot stays");

    // removal and eject of same slot in one cycle
    reg_addr = 5'h08; reg_wdata = 32'h20; reg_wr = 1'b1;
    evt_valid = 1'b1; evt_slot = 5'd5; evt_remove = 1'b1; evt_cold = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0;
    model_write(5'h08, 32'h20, ej); model_event(5, 1, 0);
    do_read(5'h04, d);
    chk("R12 down set wins", d & 32'h20, 32'h20);

    // top slot and reset drain
    do_event(31, 0, 0); do_event(31, 1, 0); do_event(0, 1, 0);
    do_write(5'h08, 32'h8000_0000);
    chk("R6 slot 31 strobe", eject_o, 32'h8000_0000);
    do_event(31, 0, 1); do_event(31, 1, 0);
    check_all("R6 before drain");
    do_reset(32'h0000_0081);
    check_all("R9 drain");
    fixed_mask = 32'h0000_FFFF;
    @(negedge clk);
    do_read(5'h0C, d);
    chk("R9 mask latched at reset", d, 32'hFFFF_FF7E);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        do_event($urandom_range(0, 31), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end else if (op < 7) begin
        d = (op == 6) ? 32'h0 : ($urandom() & $urandom());
        do_write(5'h08, d);
      end else begin
        do_write(5'(5'h10 + $urandom_range(0, 3)), 32'($urandom_range(0, 255)));
      end
      if (i % 25 == 24) check_all("R1 random");
    end
    check_all("random final");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired R1 act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule